// File: doc/BRIEF.md
# Display-Shared General-Purpose I/O Port

This block controls an 8-bit general-purpose I/O port on a small register bus. Software sees two byte-wide registers: a data register holding the values that output pins drive, and a direction register choosing for each pin whether it drives (1) or listens (0). The block drives a pad output-enable and output value per pin, and it samples the pad levels through a two-flop synchronizer so that reads see clean values.

Any pin may be taken over by a display frontplane driver outside this block. A pin is taken over when its own per-pin claim input and the global display-on input are both high. While taken over, its pad output-enable is forced low, a per-pin select output hands the pad to the display driver, and the pin's direction bit has no effect on the pad. A taken-over pin whose direction bit is 0 reads back as 1. When the claim is dropped, the direction bit controls the pin again.

Writes are single-cycle strobes carrying one byte. Reads are combinational from the address. Offsets other than the two registers read as zero and ignore writes.

Top module: `gpio_disp_port`

## Requirements
- R1: After reset the data and direction registers both read 0x00 and every pad output-enable is 0.
- R2: A write strobe at offset 0x51 stores the byte in the data register on that clock edge; a read of offset 0x51 afterwards reflects it, and pad_out equals the data register at all times.
- R3: A write strobe at offset 0x55 stores the byte in the direction register; a read of offset 0x55 returns the stored byte unchanged, regardless of display state.
- R4: In a read of offset 0x51, every bit whose direction bit is 1 returns the stored data bit, not the pad level.
- R5: In a read of offset 0x51, every bit whose direction bit is 0 and whose display takeover is active (claim bit AND display-on) returns 1.
- R6: In a read of offset 0x51, every bit whose direction bit is 0 and whose display takeover is inactive returns the pad level sampled through two register stages: a pad change is invisible after one rising edge and visible after the second.
- R7: pad_oe for each pin equals its direction bit AND NOT its takeover; a pin being taken over never has its output-enable high.
- R8: disp_sel for each pin equals its claim bit AND the display-on input.
- R9: Reads of any offset other than 0x51 and 0x55 return 0x00, and write strobes to such offsets change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_addr | input | 8 | Register offset for reads and writes |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Combinational read byte for bus_addr |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_oe | output | 8 | Pad output-enable per pin |
| pad_out | output | 8 | Pad output value per pin |
| fp_claim | input | 8 | Per-pin display frontplane claim |
| disp_on | input | 1 | Global display enable |
| disp_sel | output | 8 | Per-pin hand-over of the pad to the display driver |

## Verification
A corrupt data or direction bit shows at once on pad_out or pad_oe and in the next combinational read, so the bench compares all four port groups after every write across every direction byte, several claim patterns and both display-on states. A wrong synchronizer depth shows as read data changing one edge early or late, which the bench probes edge by edge. A decode fault shows as a nonzero read of an unused offset or as a register byte that moves after a stray write, checked at the next read.

// File: rtl/gpio_disp_pkg.sv
package gpio_disp_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= din;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[k] <= '0;
      else        stage_q[k] <= stage_q[k-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_disp_pkg::*;
#(
  parameter int            WIDTH    = 8,
  parameter int            AW       = 8,
  parameter logic [AW-1:0] DATA_OFS = 8'h51,
  parameter logic [AW-1:0] DIR_OFS  = 8'h55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] data_q,
  output logic [WIDTH-1:0] dir_q,
  output reg_sel_e         sel
);
  function automatic reg_sel_e decode(input logic [AW-1:0] a);
    if (a == DATA_OFS)     return SEL_DATA;
    else if (a == DIR_OFS) return SEL_DIR;
    else                   return SEL_NONE;
  endfunction

  assign sel = decode(addr);

  logic wr_data_hit, wr_dir_hit, wr_stray;
  assign wr_data_hit = we && (sel == SEL_DATA);
  assign wr_dir_hit  = we && (sel == SEL_DIR);
  assign wr_stray    = we && (sel == SEL_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_data_hit) data_q <= wdata;
      if (wr_dir_hit)  dir_q  <= wdata;
    end
  end

  // R2
  data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_hit |=> data_q == $past(wdata));
  // R3
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir_hit |=> dir_q == $past(wdata));
  // R9
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stray |=> $stable(data_q) && $stable(dir_q));
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] data_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] fp_claim,
  input  logic             disp_on,
  output logic [WIDTH-1:0] disp_act,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out
);
  assign disp_act = fp_claim & {WIDTH{disp_on}};

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign pad_oe[i]  = dir_q[i] & ~disp_act[i];
    assign pad_out[i] = data_q[i];
  end

  // R7
  oe_vs_display_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & disp_act) == '0);
  // R8
  display_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |-> disp_act == '0);
endmodule

// File: rtl/gpio_disp_port.sv
module gpio_disp_port
  import gpio_disp_pkg::*;
#(
  parameter int            WIDTH       = 8,
  parameter int            AW          = 8,
  parameter int            SYNC_STAGES = 2,
  parameter logic [AW-1:0] DATA_OFS    = 8'h51,
  parameter logic [AW-1:0] DIR_OFS     = 8'h55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out,
  input  logic [WIDTH-1:0] fp_claim,
  input  logic             disp_on,
  output logic [WIDTH-1:0] disp_sel
);
  logic [WIDTH-1:0] data_q, dir_q, pad_sync, disp_act, data_view;
  reg_sel_e         sel;

  gpio_regs #(.WIDTH(WIDTH), .AW(AW), .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .data_q(data_q), .dir_q(dir_q), .sel(sel)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pad_sync)
  );

  gpio_pad_ctl #(.WIDTH(WIDTH)) u_pad (
    .clk(clk), .rst_n(rst_n), .data_q(data_q), .dir_q(dir_q),
    .fp_claim(fp_claim), .disp_on(disp_on), .disp_act(disp_act),
    .pad_oe(pad_oe), .pad_out(pad_out)
  );

  assign disp_sel = disp_act;

  // Per bit: output -> stored value; input & display -> 1; input -> pad.
  function automatic logic [WIDTH-1:0] view_data(
    input logic [WIDTH-1:0] dq, input logic [WIDTH-1:0] dr,
    input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] pin);
    return (dr & dq) | (~dr & act) | (~dr & ~act & pin);
  endfunction

  assign data_view = view_data(data_q, dir_q, disp_act, pad_sync);

  always_comb begin
    unique case (sel)
      SEL_DATA: bus_rdata = data_view;
      SEL_DIR:  bus_rdata = dir_q;
      default:  bus_rdata = '0;
    endcase
  end

  // R4
  out_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_DATA) |-> (bus_rdata & dir_q) == (pad_out & dir_q));
  // R5
  disp_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_DATA) |-> (bus_rdata & ~dir_q & disp_sel) == (~dir_q & disp_sel));
  // R9
  hole_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> bus_rdata == '0);
endmodule

// File: tb/tb_gpio_disp_port.sv
module tb_gpio_disp_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic [7:0] pad_in = '0, pad_oe, pad_out, fp_claim = '0, disp_sel;
  logic       disp_on = 1'b0;

  int checks = 0, fails = 0;
  bit finished = 0;

  localparam logic [7:0] A_DATA = 8'h51, A_DIR = 8'h55;

  always #10 clk = ~clk;

  gpio_disp_port dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .fp_claim(fp_claim),
    .disp_on(disp_on), .disp_sel(disp_sel)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #2;
    d = bus_rdata;
  endtask

  // Expected read of the data offset, bit by bit from the requirements.
  function automatic logic [7:0] expect_data(input logic [7:0] dq, input logic [7:0] dr,
    input logic [7:0] cl, input logic don, input logic [7:0] pin);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      if (dr[i])              r[i] = dq[i];
      else if (cl[i] && don)  r[i] = 1'b1;
      else                    r[i] = pin[i];
    end
    return r;
  endfunction

  initial begin
    #3_000_000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] claims [4] = '{8'h00, 8'hFF, 8'hA5, 8'h3C};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(A_DATA, v); check("R1 data", v, 8'h00);
    rd(A_DIR, v);  check("R1 dir", v, 8'h00);
    check("R1 oe", pad_oe, 8'h00);

    // Sweep every direction byte over claim patterns and display states
    for (int d = 0; d < 256; d++) begin
      logic [7:0] dq, pin;
      dq  = 8'(d) ^ 8'h5A;
      pin = 8'((d * 37) + 11);
      wr(A_DIR, 8'(d));
      wr(A_DATA, dq);
      pad_in = pin;
      repeat (2) @(negedge clk);
      for (int c = 0; c < 4; c++) begin
        for (int on = 0; on < 2; on++) begin
          logic [7:0] act;
          fp_claim = claims[c]; disp_on = 1'(on);
          act = on ? claims[c] : 8'h00;
          rd(A_DATA, v);
          check("R4 R5 R6 data read", v, expect_data(dq, 8'(d), claims[c], 1'(on), pin));
          rd(A_DIR, v);
          check("R3 dir read", v, 8'(d));
          check("R7 pad_oe", pad_oe, 8'(d) & ~act);
          check("R2 pad_out", pad_out, dq);
          check("R8 disp_sel", disp_sel, act);
          @(negedge clk);
        end
      end
    end

    // R6 synchronizer latency, all pins input, display off
    fp_claim = 8'h00; disp_on = 1'b0;
    wr(A_DIR, 8'h00);
    pad_in = 8'h0F;
    repeat (3) @(negedge clk);
    pad_in = 8'hC3;
    @(negedge clk);
    rd(A_DATA, v); check("R6 after one edge", v, 8'h0F);
    @(negedge clk);
    rd(A_DATA, v); check("R6 after two edges", v, 8'hC3);

    // R9 holes: reads zero, writes ignored
    wr(A_DATA, 8'h96);
    wr(A_DIR, 8'hFF);
    for (int k = 0; k < 6; k++) begin
      logic [7:0] hole;
      hole = (k == 0) ? 8'h50 : (k == 1) ? 8'h52 : (k == 2) ? 8'h54 :
             (k == 3) ? 8'h56 : (k == 4) ? 8'h00 : 8'hFF;
      wr(hole, 8'h00);
      rd(hole, v); check("R9 hole read", v, 8'h00);
      rd(A_DATA, v); check("R9 data kept", v, 8'h96);
      rd(A_DIR, v);  check("R9 dir kept", v, 8'hFF);
    end

    // R7 direction returns when takeover ends
    fp_claim = 8'hFF; disp_on = 1'b1;
    @(negedge clk); #2;
    check("R7 claimed oe", pad_oe, 8'h00);
    disp_on = 1'b0;
    #2;
    check("R7 released oe", pad_oe, 8'hFF);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule